// File: doc/BRIEF.md
# Serial Channel Interrupt Request Controller

This block raises the interrupt requests of one serial channel. It watches the per-character receive strobe and the error flags that come with each character, the transmit-buffer-empty event and the external/status change event. It keeps a pending bit for each source, and it latches receive errors as special conditions. A channel control byte selects one of four receive interrupt policies. The same byte says whether a parity error counts as a special condition and enables the transmit and external/status sources.

A small command port clears pending state. It can re-arm first-character mode, clear the transmit pending bit, clear the external/status pending bit, clear the latched errors, or end the interrupt under service. An acknowledge input marks the current request as under service. The request line stays low until software ends that service with a command.

Top module: `rxi_irq_ctrl`

## Requirements
- R1: After reset, rx_ip_o, sc_flags_o, sc_pend_o, tx_ip_o, ext_ip_o, ius_o and irq_o are all 0, and rx_armed_o is 1.
- R2: With ctrl_i[4:3] = 00, received characters never set rx_ip_o, and sc_pend_o stays 0 even while error flags are latched.
- R3: With ctrl_i[4:3] = 10, every rx_char_i pulse sets rx_ip_o on the next edge. A rx_read_i pulse clears it.
- R4: With ctrl_i[4:3] = 01, a character sets rx_ip_o only while rx_armed_o is 1, and any character clears rx_armed_o. Command code 1 sets rx_armed_o again, and it wins over a character in the same cycle.
- R5: With ctrl_i[4:3] = 11, characters never set rx_ip_o, but latched special conditions drive sc_pend_o and the request.
- R6: On an rx_char_i pulse, each set bit of rx_err_i is latched into sc_flags_o: bit 0 overrun, bit 1 framing error, bit 2 end of frame, bit 3 parity error. The bits stay set until command code 4.
- R7: sc_pend_o is 1 when the mode is not 00 and sc_flags_o[2:0] is non-zero, or when sc_flags_o[3] is 1 and ctrl_i[2] is 1.
- R8: tx_empty_i sets tx_ip_o, and command code 2 clears it. It adds to the request only while ctrl_i[1] is 1.
- R9: ext_event_i sets ext_ip_o, and command code 3 clears it. It adds to the request only while ctrl_i[0] is 1.
- R10: irq_o is the OR of the enabled sources (rx_ip_o in modes 01/10, sc_pend_o, tx_ip_o gated by ctrl_i[1], ext_ip_o gated by ctrl_i[0]), forced low while ius_o is 1. intack_i while irq_o is 1 sets ius_o. Command code 5 clears it. Codes 0, 6 and 7 change nothing.
- R11: When a set event and its clear (read or command) fall in the same cycle, the pending bit or flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| ctrl_i | input | CTRL_W | Control byte: [4:3] receive policy, [2] parity as special, [1] transmit enable, [0] ext/status enable |
| rx_char_i | input | 1 | One-cycle pulse: a character was received |
| rx_err_i | input | 4 | Error flags qualified by rx_char_i |
| rx_read_i | input | 1 | Receive data taken; clears rx_ip_o |
| tx_empty_i | input | 1 | Transmit buffer became empty |
| ext_event_i | input | 1 | External/status change |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_i | input | CMD_W | Command code |
| intack_i | input | 1 | Interrupt acknowledge |
| rx_ip_o | output | 1 | Receive data interrupt pending |
| rx_armed_o | output | 1 | First-character mode armed |
| sc_flags_o | output | 4 | Latched special-condition flags |
| sc_pend_o | output | 1 | Special-condition request active |
| tx_ip_o | output | 1 | Transmit interrupt pending |
| ext_ip_o | output | 1 | External/status interrupt pending |
| ius_o | output | 1 | Interrupt under service |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The hardest states to reach are the same-cycle collisions: a character arriving in the cycle a re-arm command lands, an error arriving together with the error-clear command, and a read together with a new character. Directed sequences line these up in single cycles for each receive policy. A long stretch of random stimulus then mixes every event, command, acknowledge and control byte. The reference model follows along every clock and checks the armed state, the latched flags and the under-service gating of the request.

// File: rtl/rxi_pkg.sv
package rxi_pkg;
   typedef enum logic [1:0] {
      RXM_OFF     = 2'b00,
      RXM_FIRST   = 2'b01,
      RXM_ALL     = 2'b10,
      RXM_SC_ONLY = 2'b11
   } rx_mode_e;

   typedef enum logic [2:0] {
      CMD_NONE    = 3'd0,
      CMD_REARM   = 3'd1,
      CMD_CLR_TX  = 3'd2,
      CMD_CLR_EXT = 3'd3,
      CMD_CLR_ERR = 3'd4,
      CMD_CLR_IUS = 3'd5
   } cmd_e;

   localparam int SC_NUM   = 4;
   localparam int SC_PAR   = 3;
   localparam int MODE_LSB = 3;
   localparam int PAR_BIT  = 2;
   localparam int TIE_BIT  = 1;
   localparam int SIE_BIT  = 0;
   localparam int CMD_MINW = 3;
endpackage

// File: rtl/rxi_cmd_dec.sv
module rxi_cmd_dec
   import rxi_pkg::*;
#(
   parameter int CMD_W = 3
) (
   input  logic             cmd_valid_i,
   input  logic [CMD_W-1:0] cmd_i,
   output logic             rearm_o,
   output logic             clr_tx_o,
   output logic             clr_ext_o,
   output logic             clr_err_o,
   output logic             clr_ius_o
);
   if (CMD_W < CMD_MINW) begin : g_bad_cmd_w
      $error("rxi_cmd_dec: CMD_W too narrow for the command set");
   end

   always_comb begin
      rearm_o   = cmd_valid_i && (cmd_i == CMD_W'(CMD_REARM));
      clr_tx_o  = cmd_valid_i && (cmd_i == CMD_W'(CMD_CLR_TX));
      clr_ext_o = cmd_valid_i && (cmd_i == CMD_W'(CMD_CLR_EXT));
      clr_err_o = cmd_valid_i && (cmd_i == CMD_W'(CMD_CLR_ERR));
      clr_ius_o = cmd_valid_i && (cmd_i == CMD_W'(CMD_CLR_IUS));
   end
endmodule

// File: rtl/rxi_sticky_bank.sv
module rxi_sticky_bank #(
   parameter int N        = 1,
   parameter bit SET_WINS = 1'b1
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] q_o
);
   if (N < 1) begin : g_bad_n
      $error("rxi_sticky_bank: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      logic nxt;
      if (SET_WINS) begin : g_set_first
         always_comb nxt = set_i[i] | (q_o[i] & ~clr_i[i]);
      end else begin : g_clr_first
         always_comb nxt = ~clr_i[i] & (set_i[i] | q_o[i]);
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) q_o[i] <= 1'b0;
         else         q_o[i] <= nxt;
      end
   end
endmodule

// File: rtl/rxi_rx_data.sv
module rxi_rx_data
   import rxi_pkg::*;
(
   input  logic     clk_i,
   input  logic     rst_ni,
   input  rx_mode_e mode_i,
   input  logic     rx_char_i,
   input  logic     rx_read_i,
   input  logic     rearm_i,
   output logic     rx_ip_o,
   output logic     armed_o
);
   logic take;

   always_comb begin
      unique case (mode_i)
         RXM_ALL:   take = rx_char_i;
         RXM_FIRST: take = rx_char_i & armed_o;
         default:   take = 1'b0;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         armed_o <= 1'b1;
         rx_ip_o <= 1'b0;
      end else begin
         if (rearm_i)                               armed_o <= 1'b1;
         else if (rx_char_i && mode_i == RXM_FIRST) armed_o <= 1'b0;
         rx_ip_o <= take | (rx_ip_o & ~rx_read_i);
      end
   end
endmodule

// File: rtl/rxi_irq_ctrl.sv
module rxi_irq_ctrl
   import rxi_pkg::*;
#(
   parameter int CTRL_W   = 8,
   parameter int CMD_W    = 3,
   parameter bit SET_WINS = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [CTRL_W-1:0] ctrl_i,
   input  logic              rx_char_i,
   input  logic [3:0]        rx_err_i,
   input  logic              rx_read_i,
   input  logic              tx_empty_i,
   input  logic              ext_event_i,
   input  logic              cmd_valid_i,
   input  logic [CMD_W-1:0]  cmd_i,
   input  logic              intack_i,
   output logic              rx_ip_o,
   output logic              rx_armed_o,
   output logic [3:0]        sc_flags_o,
   output logic              sc_pend_o,
   output logic              tx_ip_o,
   output logic              ext_ip_o,
   output logic              ius_o,
   output logic              irq_o
);
   localparam int MODE_MSB = MODE_LSB + 1;

   if (CTRL_W <= MODE_MSB) begin : g_bad_ctrl_w
      $error("rxi_irq_ctrl: CTRL_W must hold the mode field");
   end
   if (SC_NUM != 4) begin : g_bad_sc_num
      $error("rxi_irq_ctrl: flag vector width mismatch");
   end

   rx_mode_e mode;
   logic rearm, clr_tx, clr_ext, clr_err, clr_ius;
   logic [1:0] evt_q;
   logic sc_any, rx_req, raw_req;

   assign mode = rx_mode_e'(ctrl_i[MODE_MSB:MODE_LSB]);

   rxi_cmd_dec #(.CMD_W(CMD_W)) u_dec (
      .cmd_valid_i (cmd_valid_i),
      .cmd_i       (cmd_i),
      .rearm_o     (rearm),
      .clr_tx_o    (clr_tx),
      .clr_ext_o   (clr_ext),
      .clr_err_o   (clr_err),
      .clr_ius_o   (clr_ius)
   );

   rxi_rx_data u_rx (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .mode_i    (mode),
      .rx_char_i (rx_char_i),
      .rx_read_i (rx_read_i),
      .rearm_i   (rearm),
      .rx_ip_o   (rx_ip_o),
      .armed_o   (rx_armed_o)
   );

   rxi_sticky_bank #(.N(SC_NUM), .SET_WINS(SET_WINS)) u_sc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (rx_err_i & {SC_NUM{rx_char_i}}),
      .clr_i  ({SC_NUM{clr_err}}),
      .q_o    (sc_flags_o)
   );

   rxi_sticky_bank #(.N(2), .SET_WINS(SET_WINS)) u_evt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  ({ext_event_i, tx_empty_i}),
      .clr_i  ({clr_ext, clr_tx}),
      .q_o    (evt_q)
   );

   assign tx_ip_o  = evt_q[0];
   assign ext_ip_o = evt_q[1];

   always_comb begin
      sc_any    = (|sc_flags_o[SC_PAR-1:0]) | (sc_flags_o[SC_PAR] & ctrl_i[PAR_BIT]);
      sc_pend_o = sc_any & (mode != RXM_OFF);
      rx_req    = rx_ip_o & ((mode == RXM_FIRST) | (mode == RXM_ALL));
      raw_req   = rx_req | sc_pend_o
                | (tx_ip_o & ctrl_i[TIE_BIT])
                | (ext_ip_o & ctrl_i[SIE_BIT]);
      irq_o     = raw_req & ~ius_o;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                ius_o <= 1'b0;
      else if (clr_ius)           ius_o <= 1'b0;
      else if (intack_i && irq_o) ius_o <= 1'b1;
   end
endmodule

// File: rtl/rxi_irq_ctrl_chk.sv
module rxi_irq_ctrl_chk
   import rxi_pkg::*;
#(
   parameter int CTRL_W = 8,
   parameter int CMD_W  = 3
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic [CTRL_W-1:0] ctrl_i,
   input logic              rx_char_i,
   input logic [3:0]        rx_err_i,
   input logic              rx_read_i,
   input logic              tx_empty_i,
   input logic              ext_event_i,
   input logic              cmd_valid_i,
   input logic [CMD_W-1:0]  cmd_i,
   input logic              intack_i,
   input logic              rx_ip_o,
   input logic              rx_armed_o,
   input logic [3:0]        sc_flags_o,
   input logic              sc_pend_o,
   input logic              tx_ip_o,
   input logic              ext_ip_o,
   input logic              ius_o,
   input logic              irq_o
);
   logic [1:0] md;
   logic is_rearm, is_clr_tx, is_clr_err;
   assign md         = ctrl_i[MODE_LSB+1:MODE_LSB];
   assign is_rearm   = cmd_valid_i && cmd_i == CMD_W'(CMD_REARM);
   assign is_clr_tx  = cmd_valid_i && cmd_i == CMD_W'(CMD_CLR_TX);
   assign is_clr_err = cmd_valid_i && cmd_i == CMD_W'(CMD_CLR_ERR);

   AST_IUS_BLOCKS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ius_o |-> !irq_o); // R10
   AST_OFF_NO_RX: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (md == 2'b00 && rx_char_i && !rx_ip_o) |=> !rx_ip_o); // R2
   AST_ALL_EVERY_CHAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (md == 2'b10 && rx_char_i) |=> rx_ip_o); // R3
   AST_FIRST_DISARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (md == 2'b01 && rx_char_i && !is_rearm) |=> !rx_armed_o); // R4
   AST_SC_ONLY_NO_RX: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (md == 2'b11 && rx_char_i && !rx_ip_o) |=> !rx_ip_o); // R5
   AST_SC_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !is_clr_err |=> ((sc_flags_o & $past(sc_flags_o)) == $past(sc_flags_o))); // R6
   AST_PAR_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ctrl_i[PAR_BIT] && sc_flags_o[2:0] == 3'b000) |-> !sc_pend_o); // R7
   AST_TX_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (is_clr_tx && !tx_empty_i) |=> !tx_ip_o); // R8
   AST_EXT_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ext_event_i |=> ext_ip_o); // R11
endmodule

bind rxi_irq_ctrl rxi_irq_ctrl_chk #(.CTRL_W(CTRL_W), .CMD_W(CMD_W)) u_chk (.*);

// File: tb/rxi_irq_ctrl_tb.sv
`timescale 1ns/1ps
module rxi_irq_ctrl_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] ctrl = 8'h00;
   logic       rx_char = 0, rx_read = 0, tx_empty = 0, ext_event = 0;
   logic [3:0] rx_err = 4'h0;
   logic       cmd_valid = 0, intack = 0;
   logic [2:0] cmd = 3'd0;
   logic       rx_ip, rx_armed, sc_pend, tx_ip, ext_ip, ius, irq;
   logic [3:0] sc_flags;

   int n_cmp = 0, n_bad = 0;
   bit done = 0;

   // reference model state
   bit m_armed = 1, m_rx = 0, m_tx = 0, m_ext = 0, m_ius = 0;
   bit [3:0] m_sc = 0;

   always #2.5 clk = ~clk;

   rxi_irq_ctrl dut_i (
      .clk_i(clk), .rst_ni(rst_n), .ctrl_i(ctrl), .rx_char_i(rx_char),
      .rx_err_i(rx_err), .rx_read_i(rx_read), .tx_empty_i(tx_empty),
      .ext_event_i(ext_event), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
      .intack_i(intack), .rx_ip_o(rx_ip), .rx_armed_o(rx_armed),
      .sc_flags_o(sc_flags), .sc_pend_o(sc_pend), .tx_ip_o(tx_ip),
      .ext_ip_o(ext_ip), .ius_o(ius), .irq_o(irq));

   function automatic bit m_scpend();
      bit act = (m_sc[2:0] != 0) || (m_sc[3] && ctrl[2]);
      return act && (ctrl[4:3] != 2'b00);
   endfunction

   function automatic bit m_irq();
      bit rxq = m_rx && (ctrl[4:3] == 2'b01 || ctrl[4:3] == 2'b10);
      bit raw = rxq || m_scpend() || (m_tx && ctrl[1]) || (m_ext && ctrl[0]);
      return raw && !m_ius;
   endfunction

   task automatic model_step();
      bit cv1 = cmd_valid && cmd == 3'd1;
      bit cv2 = cmd_valid && cmd == 3'd2;
      bit cv3 = cmd_valid && cmd == 3'd3;
      bit cv4 = cmd_valid && cmd == 3'd4;
      bit cv5 = cmd_valid && cmd == 3'd5;
      bit irq_now = m_irq();
      bit take = rx_char && (ctrl[4:3] == 2'b10 || (ctrl[4:3] == 2'b01 && m_armed));
      m_rx = take || (m_rx && !rx_read);
      if (cv1) m_armed = 1;
      else if (rx_char && ctrl[4:3] == 2'b01) m_armed = 0;
      for (int i = 0; i < 4; i++)
         m_sc[i] = (rx_char && rx_err[i]) || (m_sc[i] && !cv4);
      m_tx  = tx_empty || (m_tx && !cv2);
      m_ext = ext_event || (m_ext && !cv3);
      if (cv5) m_ius = 0;
      else if (intack && irq_now) m_ius = 1;
   endtask

   task automatic chk(string tag, string nm, logic [3:0] act, logic [3:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, nm, act, exp);
      end
   endtask

   task automatic compare_all();
      chk("R3", "rx_ip", {3'b0, rx_ip}, {3'b0, m_rx});
      chk("R4", "rx_armed", {3'b0, rx_armed}, {3'b0, m_armed});
      chk("R6", "sc_flags", sc_flags, m_sc);
      chk("R7", "sc_pend", {3'b0, sc_pend}, {3'b0, m_scpend()});
      chk("R8", "tx_ip", {3'b0, tx_ip}, {3'b0, m_tx});
      chk("R9", "ext_ip", {3'b0, ext_ip}, {3'b0, m_ext});
      chk("R10", "ius", {3'b0, ius}, {3'b0, m_ius});
      chk("R10", "irq", {3'b0, irq}, {3'b0, m_irq()});
   endtask

   task automatic clear_in();
      rx_char = 0; rx_err = 0; rx_read = 0; tx_empty = 0; ext_event = 0;
      cmd_valid = 0; cmd = 0; intack = 0;
   endtask

   // one clock: inputs already set at a falling edge
   task automatic cyc();
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare_all();
      clear_in();
   endtask

   task automatic chr(logic [3:0] e);
      rx_char = 1; rx_err = e; cyc();
   endtask

   task automatic command(logic [2:0] c);
      cmd_valid = 1; cmd = c; cyc();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #500000;
      n_bad++;
      $display("FAIL R1 watchdog: actual hung expected finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      compare_all();
      chk("R1", "armed_at_reset", {3'b0, rx_armed}, 4'd1);
      rst_n = 1;
      cyc();

      // R3: every character, read clears, R11 read plus char keeps set
      ctrl = 8'h10;
      chr(4'h0); chr(4'h0);
      rx_read = 1; cyc();
      rx_read = 1; rx_char = 1; cyc();
      rx_read = 1; cyc();

      // R4: first-character mode
      ctrl = 8'h08;
      command(3'd1);
      chr(4'h0); chr(4'h0);
      rx_read = 1; cyc();
      chr(4'h0);
      command(3'd1);
      chr(4'h0);
      rx_read = 1; cyc();
      rx_char = 1; cmd_valid = 1; cmd = 3'd1; cyc();
      chr(4'h0);
      rx_read = 1; cyc();

      // R2: mode off, errors latch but do not request
      ctrl = 8'h04;
      chr(4'h0); chr(4'h1); chr(4'h8); cyc();
      command(3'd4);

      // R5: special-condition-only mode
      ctrl = 8'h18;
      chr(4'h0); chr(4'h0);
      chr(4'h2); cyc();
      command(3'd4);
      chr(4'h4); command(3'd4);

      // R7: parity only counts with control bit 2
      chr(4'h8); cyc();
      ctrl = 8'h1C; cyc();
      ctrl = 8'h18; cyc();
      // R11: error arriving with the clear command stays latched
      rx_char = 1; rx_err = 4'h1; cmd_valid = 1; cmd = 3'd4; cyc();
      command(3'd4);

      // R8: transmit pending and its enable
      ctrl = 8'h00;
      tx_empty = 1; cyc();
      ctrl = 8'h02; cyc();
      command(3'd2);
      tx_empty = 1; cmd_valid = 1; cmd = 3'd2; cyc();
      command(3'd2);

      // R9: external/status pending and its enable
      ext_event = 1; cyc();
      ctrl = 8'h01; cyc();
      command(3'd3);

      // R10: acknowledge, gating, end of service, no-op codes
      ext_event = 1; cyc();
      intack = 1; cyc();
      command(3'd6); command(3'd7); command(3'd0);
      intack = 1; cyc();
      command(3'd3);
      command(3'd5);
      intack = 1; cyc();

      // mixed random stimulus against the model
      for (int k = 0; k < 2000; k++) begin
         if (k % 97 == 0) ctrl = 8'($urandom_range(0, 31));
         rx_char   = ($urandom_range(0, 3) == 0);
         rx_err    = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(0, 15)) : 4'h0;
         rx_read   = ($urandom_range(0, 4) == 0);
         tx_empty  = ($urandom_range(0, 9) == 0);
         ext_event = ($urandom_range(0, 9) == 0);
         cmd_valid = ($urandom_range(0, 3) == 0);
         cmd       = 3'($urandom_range(0, 7));
         intack    = ($urandom_range(0, 5) == 0);
         cyc();
      end
      finish_run();
   end
endmodule